// File: doc/BRIEF.md
# Dual-Mode Host Bus Target

This block is the slave end of a host processor bus. It sits in front of a small word-addressed memory and a bank of 32-bit registers. The host can read or write either one. The data path is 32 bits wide and split into two 16-bit lanes, and a two-bit lane-enable input picks which halves take part in a memory access. A static strap selects how the handshake is timed:

- **Strobe-driven (asynchronous) mode:** the select and strobe inputs are resynchronised inside the block. The active-low ready output is held low until the host lets go of the strobe.
- **Clocked (synchronous) mode:** ready is a single-cycle pulse. An active-low stop output ends register reads, terminates bursts, and rejects transfers that cannot complete.

In clocked mode the host holds the last-beat input high to keep a memory burst running. The word address steps up by one after each accepted beat, and there is one idle cycle between beats. A second strap places the address either on its own bus or on the low bits of the write-data bus, which is sampled in the cycle that starts the transfer. After a stop, the block ignores requests for one further cycle.

Top module: `hbus_target`

## Requirements
- R1: After reset, ready_n and stop_n are both 1 and rdata_out is zero.
- R2: In clocked mode (mode_async=0), a valid access seen at clock edge E (sel_n=0, strb_n=0) drives ready_n low for exactly one cycle, starting at edge E+1. Read data is valid on rdata_out in that cycle, and write data is sampled at E+1.
- R3: In clocked mode, a register read that completes drives stop_n low in the same cycle as the ready pulse. A register write with last_n=1 also ends this way.
- R4: In clocked mode, a valid memory read, a valid memory write, or a register write with last_n=0 completes with ready_n low and stop_n high.
- R5: In clocked mode, an invalid access drives stop_n low for one cycle with ready_n high, and writes nothing.
- R6: In clocked mode, a request held during the cycle in which stop_n returns high is ignored. A request is accepted no earlier than the following edge.
- R7: In clocked mode, a memory beat with last_n=1 continues the burst. The next beat follows two cycles later at address +1, with ready_n high in the cycle between. A beat with last_n=0 ends the burst. A burst that steps past the last memory word is aborted on that beat as in R5.
- R8: word_en bit k covers data bits [16k+15:16k]. A memory access needs at least one bit set. Lanes that are not enabled keep their stored value and read as zero. A register access needs word_en=2'b11, and anything else is invalid.
- R9: In strobe mode (mode_async=1), ready_n falls four edges after select and strobe go low. It stays low while the strobe is held, and rises on the third edge after strb_n returns to 1. stop_n stays 1 and last_n has no effect.
- R10: With mux_bus=1, the address is taken from wdata_in[ADDR_W-1:0] at the starting edge and addr_in is ignored. With mux_bus=0, addr_in is used.
- R11: Word addresses 0 to MEM_DEPTH-1 (0..15) select memory and REG_BASE to REG_BASE+REG_COUNT-1 (0x80..0x83) select registers. Every other address is invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_async | input | 1 | Static strap: 1 strobe-driven mode, 0 clocked mode |
| mux_bus | input | 1 | Static strap: 1 address on write-data bus, 0 separate address bus |
| sel_n | input | 1 | Active-low target select |
| strb_n | input | 1 | Active-low data strobe |
| wr | input | 1 | 1 write, 0 read |
| last_n | input | 1 | Clocked mode: 1 burst continues, 0 final or single beat |
| word_en | input | 2 | 16-bit lane enables |
| addr_in | input | ADDR_W | Word address on the separate address bus |
| wdata_in | input | 2*HALF_W | Write data (also the address in multiplexed mode) |
| rdata_out | output | 2*HALF_W | Read data |
| ready_n | output | 1 | Active-low transfer-ready handshake |
| stop_n | output | 1 | Active-low terminate/abort (clocked mode) |

## Verification
The assertions assume that the mode strap changes only while reset is active. They also assume that a clocked-mode host drops its request once it sees ready or stop, unless it is continuing a burst or deliberately holding through the stop window. The strobe-release property assumes the strobe stays high for at least two cycles once it has been released. The bench changes the strap only inside a reset pulse and drives every input on the falling edge. It releases each request in the cycle after the handshake and holds it through the stop window only in the directed scenario that tests that window.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BEAT,
    ST_GAP,
    ST_STOPW,
    ST_AHOLD
  } hbus_state_e;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/hbus_decode.sv
module hbus_decode #(
  parameter int ADDR_W    = 8,
  parameter int MEM_DEPTH = 16,
  parameter int REG_BASE  = 128,
  parameter int REG_COUNT = 4,
  localparam int MIDX_W   = $clog2(MEM_DEPTH),
  localparam int RIDX_W   = $clog2(REG_COUNT)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        lane_en,
  output logic              is_mem,
  output logic              is_reg,
  output logic              valid,
  output logic [MIDX_W-1:0] mem_idx,
  output logic [RIDX_W-1:0] reg_idx
);
  int addr_int;

  always_comb begin
    addr_int = int'(addr);
    is_mem   = addr_int < MEM_DEPTH;
    is_reg   = (addr_int >= REG_BASE) && (addr_int < REG_BASE + REG_COUNT);
    // memory needs any lane; registers are full-width only
    if (is_mem)      valid = |lane_en;
    else if (is_reg) valid = &lane_en;
    else             valid = 1'b0;
    mem_idx  = addr[MIDX_W-1:0];
    reg_idx  = RIDX_W'(addr_int - REG_BASE);
  end
endmodule

// File: rtl/hbus_store.sv
module hbus_store #(
  parameter int HALF_W    = 16,
  parameter int MEM_DEPTH = 16,
  parameter int REG_COUNT = 4,
  localparam int LANES    = 2,
  localparam int DATA_W   = LANES * HALF_W,
  localparam int MIDX_W   = $clog2(MEM_DEPTH),
  localparam int RIDX_W   = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_we,
  input  logic              reg_we,
  input  logic              sel_reg,
  input  logic [LANES-1:0]  lane_en,
  input  logic [MIDX_W-1:0] mem_idx,
  input  logic [RIDX_W-1:0] reg_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [HALF_W-1:0] mem_q [MEM_DEPTH];
    logic [HALF_W-1:0] reg_q [REG_COUNT];
    logic              mem_en;
    logic              reg_en;

    assign mem_en = mem_we & lane_en[g];
    assign reg_en = reg_we & lane_en[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= '0;
      end else if (mem_en) begin
        mem_q[mem_idx] <= wdata[g*HALF_W +: HALF_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < REG_COUNT; i++) reg_q[i] <= '0;
      end else if (reg_en) begin
        reg_q[reg_idx] <= wdata[g*HALF_W +: HALF_W];
      end
    end

    always_comb begin
      if (!lane_en[g])  rd_word[g*HALF_W +: HALF_W] = '0;
      else if (sel_reg) rd_word[g*HALF_W +: HALF_W] = reg_q[reg_idx];
      else              rd_word[g*HALF_W +: HALF_W] = mem_q[mem_idx];
    end
  end
endmodule

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
  import hbus_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_async,
  input  logic              req,
  input  logic              strb_rel,
  input  logic              last_n,
  input  logic              wr_in,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              valid,
  input  logic              is_mem,
  input  logic              is_reg,
  output logic [ADDR_W-1:0] addr_q,
  output logic              ready_q,
  output logic              stop_q,
  output logic              mem_we,
  output logic              reg_we,
  output logic              rd_cap
);
  hbus_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;
  logic              wr_q, wr_d;
  logic              ready_d, stop_d;

  always_comb begin
    state_d = state_q;
    addr_en = 1'b0;
    addr_d  = addr_q;
    wr_d    = wr_q;
    ready_d = 1'b0;
    stop_d  = 1'b0;
    mem_we  = 1'b0;
    reg_we  = 1'b0;
    rd_cap  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          state_d = ST_BEAT;
          addr_en = 1'b1;
          addr_d  = start_addr;
          wr_d    = wr_in;
        end
      end
      ST_BEAT: begin
        rd_cap = ~wr_q;
        if (mode_async) begin
          ready_d = 1'b1;
          mem_we  = wr_q & valid & is_mem;
          reg_we  = wr_q & valid & is_reg;
          state_d = ST_AHOLD;
        end else if (!valid) begin
          stop_d  = 1'b1;
          state_d = ST_STOPW;
        end else begin
          ready_d = 1'b1;
          mem_we  = wr_q & is_mem;
          reg_we  = wr_q & is_reg;
          if (is_reg && (!wr_q || last_n)) begin
            stop_d  = 1'b1;
            state_d = ST_STOPW;
          end else if (last_n) begin
            state_d = ST_GAP;
            addr_en = 1'b1;
            addr_d  = addr_q + 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_GAP:   state_d = ST_BEAT;
      ST_STOPW: state_d = ST_IDLE;
      ST_AHOLD: begin
        if (strb_rel) state_d = ST_IDLE;
        else          ready_d = 1'b1;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      ready_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
      ready_q <= ready_d;
      stop_q  <= stop_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end
endmodule

// File: rtl/hbus_target.sv
module hbus_target #(
  parameter int ADDR_W    = 8,
  parameter int HALF_W    = 16,
  parameter int MEM_DEPTH = 16,
  parameter int REG_BASE  = 128,
  parameter int REG_COUNT = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_async,
  input  logic                  mux_bus,
  input  logic                  sel_n,
  input  logic                  strb_n,
  input  logic                  wr,
  input  logic                  last_n,
  input  logic [1:0]            word_en,
  input  logic [ADDR_W-1:0]     addr_in,
  input  logic [2*HALF_W-1:0]   wdata_in,
  output logic [2*HALF_W-1:0]   rdata_out,
  output logic                  ready_n,
  output logic                  stop_n
);
  localparam int DATA_W = 2 * HALF_W;
  localparam int MIDX_W = $clog2(MEM_DEPTH);
  localparam int RIDX_W = $clog2(REG_COUNT);

  logic [1:0]        strb_sync;
  logic              sel_eff, strb_eff, req;
  logic [ADDR_W-1:0] start_addr, addr_q;
  logic              is_mem, is_reg, valid;
  logic [MIDX_W-1:0] mem_idx;
  logic [RIDX_W-1:0] reg_idx;
  logic              ready_q, stop_q, mem_we, reg_we, rd_cap;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rdata_q;

  hbus_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sel_n, strb_n}),
    .q     (strb_sync)
  );

  assign sel_eff    = mode_async ? strb_sync[1] : sel_n;
  assign strb_eff   = mode_async ? strb_sync[0] : strb_n;
  assign req        = ~sel_eff & ~strb_eff;
  assign start_addr = mux_bus ? wdata_in[ADDR_W-1:0] : addr_in;

  hbus_decode #(
    .ADDR_W(ADDR_W), .MEM_DEPTH(MEM_DEPTH),
    .REG_BASE(REG_BASE), .REG_COUNT(REG_COUNT)
  ) u_decode (
    .addr    (addr_q),
    .lane_en (word_en),
    .is_mem  (is_mem),
    .is_reg  (is_reg),
    .valid   (valid),
    .mem_idx (mem_idx),
    .reg_idx (reg_idx)
  );

  hbus_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_async (mode_async),
    .req        (req),
    .strb_rel   (strb_eff),
    .last_n     (last_n),
    .wr_in      (wr),
    .start_addr (start_addr),
    .valid      (valid),
    .is_mem     (is_mem),
    .is_reg     (is_reg),
    .addr_q     (addr_q),
    .ready_q    (ready_q),
    .stop_q     (stop_q),
    .mem_we     (mem_we),
    .reg_we     (reg_we),
    .rd_cap     (rd_cap)
  );

  hbus_store #(
    .HALF_W(HALF_W), .MEM_DEPTH(MEM_DEPTH), .REG_COUNT(REG_COUNT)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_we  (mem_we),
    .reg_we  (reg_we),
    .sel_reg (is_reg),
    .lane_en (word_en),
    .mem_idx (mem_idx),
    .reg_idx (reg_idx),
    .wdata   (wdata_in),
    .rd_word (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_cap) rdata_q <= valid ? rd_word : '0;
  end

  assign rdata_out = rdata_q;
  assign ready_n   = ~ready_q;
  assign stop_n    = ~stop_q;
endmodule

// File: rtl/hbus_target_chk.sv
module hbus_target_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_async,
  input logic strb_n,
  input logic ready_n,
  input logic stop_n
);
  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_async && !ready_n) |=> ready_n);

  assert_stop_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n) |=> stop_n);

  assert_stop_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_async && $rose(stop_n)) |=> (ready_n && stop_n));

  assert_async_no_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_async |-> stop_n);

  assert_async_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_async && $rose(ready_n)) |-> $past(strb_n, 2));
endmodule

bind hbus_target hbus_target_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_async (mode_async),
  .strb_n     (strb_n),
  .ready_n    (ready_n),
  .stop_n     (stop_n)
);

// File: tb/hbus_target_bench.sv
module hbus_target_bench;
  logic        clk;
  logic        rst_n;
  logic        mode_async;
  logic        mux_bus;
  logic        sel_n;
  logic        strb_n;
  logic        wr;
  logic        last_n;
  logic [1:0]  word_en;
  logic [7:0]  addr_in;
  logic [31:0] wdata_in;
  logic [31:0] rdata_out;
  logic        ready_n;
  logic        stop_n;

  int n_chk = 0;
  int n_err = 0;

  hbus_target u_hbus_target (
    .clk(clk), .rst_n(rst_n), .mode_async(mode_async), .mux_bus(mux_bus),
    .sel_n(sel_n), .strb_n(strb_n), .wr(wr), .last_n(last_n),
    .word_en(word_en), .addr_in(addr_in), .wdata_in(wdata_in),
    .rdata_out(rdata_out), .ready_n(ready_n), .stop_n(stop_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_idle();
    sel_n = 1'b1; strb_n = 1'b1; wr = 1'b0; last_n = 1'b0;
    word_en = 2'b11; addr_in = 8'h00; wdata_in = 32'h0;
  endtask

  task automatic do_reset(input logic am, input logic mm);
    @(negedge clk);
    rst_n = 1'b0; mode_async = am; mux_bus = mm;
    bus_idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one clocked-mode transfer; checks handshake and optionally read data
  task automatic sync_xfer(input string req, input logic [7:0] a, input logic w,
                           input logic [1:0] we, input logic [31:0] d,
                           input logic exp_rdy, input logic exp_stop,
                           input logic chk_rd, input logic [31:0] exp_rd);
    @(negedge clk);
    sel_n = 1'b0; strb_n = 1'b0; wr = w; word_en = we; last_n = 1'b0;
    addr_in  = mux_bus ? 8'h5A : a;
    wdata_in = mux_bus ? {24'h0, a} : d;
    @(negedge clk);
    check(req, "ready before response", 32'(ready_n), 32'd1);
    wdata_in = d;
    @(negedge clk);
    check(req, "ready_n", 32'(ready_n), 32'(!exp_rdy));
    check(req, "stop_n", 32'(stop_n), 32'(!exp_stop));
    if (chk_rd) check(req, "rdata", rdata_out, exp_rd);
    sel_n = 1'b1; strb_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b0);
    check("R1", "ready_n after reset", 32'(ready_n), 32'd1);
    check("R1", "stop_n after reset", 32'(stop_n), 32'd1);
    check("R1", "rdata after reset", rdata_out, 32'h0);
  endtask

  task automatic t_single();
    sync_xfer("R4", 8'h03, 1'b1, 2'b11, 32'h1234_5678, 1'b1, 1'b0, 1'b0, 32'h0);
    sync_xfer("R2", 8'h03, 1'b0, 2'b11, 32'h0, 1'b1, 1'b0, 1'b1, 32'h1234_5678);
    sync_xfer("R4", 8'h81, 1'b1, 2'b11, 32'hCAFE_F00D, 1'b1, 1'b0, 1'b0, 32'h0);
    sync_xfer("R3", 8'h81, 1'b0, 2'b11, 32'h0, 1'b1, 1'b1, 1'b1, 32'hCAFE_F00D);
    sync_xfer("R11", 8'h0F, 1'b1, 2'b11, 32'h0F0F_0F0F, 1'b1, 1'b0, 1'b0, 32'h0);
    sync_xfer("R11", 8'h0F, 1'b0, 2'b11, 32'h0, 1'b1, 1'b0, 1'b1, 32'h0F0F_0F0F);
    sync_xfer("R11", 8'h83, 1'b0, 2'b11, 32'h0, 1'b1, 1'b1, 1'b1, 32'h0);
  endtask

  task automatic t_invalid();
    sync_xfer("R5", 8'h40, 1'b0, 2'b11, 32'h0, 1'b0, 1'b1, 1'b0, 32'h0);
    sync_xfer("R11", 8'h84, 1'b0, 2'b11, 32'h0, 1'b0, 1'b1, 1'b0, 32'h0);
    sync_xfer("R5", 8'h7F, 1'b1, 2'b11, 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b0, 32'h0);
    sync_xfer("R5", 8'h10, 1'b1, 2'b11, 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b0, 32'h0);
    sync_xfer("R5", 8'h03, 1'b1, 2'b00, 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b0, 32'h0);
    sync_xfer("R5", 8'h03, 1'b0, 2'b11, 32'h0, 1'b1, 1'b0, 1'b1, 32'h1234_5678);
  endtask

  task automatic t_lanes();
    sync_xfer("R8", 8'h07, 1'b1, 2'b11, 32'hAAAA_BBBB, 1'b1, 1'b0, 1'b0, 32'h0);
    sync_xfer("R8", 8'h07, 1'b1, 2'b01, 32'h1111_2222, 1'b1, 1'b0, 1'b0, 32'h0);
    sync_xfer("R8", 8'h07, 1'b0, 2'b11, 32'h0, 1'b1, 1'b0, 1'b1, 32'hAAAA_2222);
    sync_xfer("R8", 8'h07, 1'b0, 2'b10, 32'h0, 1'b1, 1'b0, 1'b1, 32'hAAAA_0000);
    sync_xfer("R8", 8'h81, 1'b1, 2'b01, 32'h5555_5555, 1'b0, 1'b1, 1'b0, 32'h0);
    sync_xfer("R8", 8'h81, 1'b0, 2'b11, 32'h0, 1'b1, 1'b1, 1'b1, 32'hCAFE_F00D);
  endtask

  task automatic t_stop_gap();
    @(negedge clk);
    sel_n = 1'b0; strb_n = 1'b0; wr = 1'b0; word_en = 2'b11;
    last_n = 1'b0; addr_in = 8'h40;
    @(negedge clk);
    addr_in = 8'h03;
    @(negedge clk);
    check("R6", "stop_n on abort", 32'(stop_n), 32'd0);
    check("R6", "ready_n on abort", 32'(ready_n), 32'd1);
    @(negedge clk);
    check("R6", "stop_n released", 32'(stop_n), 32'd1);
    @(negedge clk);
    check("R6", "no ready one cycle after release", 32'(ready_n), 32'd1);
    @(negedge clk);
    check("R6", "held request served later", 32'(ready_n), 32'd0);
    check("R6", "rdata of held request", rdata_out, 32'h1234_5678);
    sel_n = 1'b1; strb_n = 1'b1;
  endtask

  task automatic burst(input logic w, input logic [7:0] a, input int n);
    @(negedge clk);
    sel_n = 1'b0; strb_n = 1'b0; wr = w; word_en = 2'b11;
    addr_in = a; last_n = (n > 1); wdata_in = 32'hB000_0000;
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check("R7", "beat ready_n", 32'(ready_n), 32'd0);
      check("R7", "beat stop_n", 32'(stop_n), 32'd1);
      if (!w) check("R7", "burst rdata", rdata_out, 32'hB000_0000 + 32'(k));
      if (k < n - 1) begin
        wdata_in = 32'hB000_0000 + 32'(k + 1);
        last_n = (k + 1 < n - 1);
        @(negedge clk);
        check("R7", "gap ready_n", 32'(ready_n), 32'd1);
      end
    end
    sel_n = 1'b1; strb_n = 1'b1;
  endtask

  task automatic t_burst();
    burst(1'b1, 8'h08, 3);
    sync_xfer("R7", 8'h09, 1'b0, 2'b11, 32'h0, 1'b1, 1'b0, 1'b1, 32'hB000_0001);
    sync_xfer("R7", 8'h0A, 1'b0, 2'b11, 32'h0, 1'b1, 1'b0, 1'b1, 32'hB000_0002);
    sync_xfer("R7", 8'h0B, 1'b0, 2'b11, 32'h0, 1'b1, 1'b0, 1'b1, 32'h0);
    burst(1'b0, 8'h08, 3);
    // burst running off the memory end
    @(negedge clk);
    sel_n = 1'b0; strb_n = 1'b0; wr = 1'b1; addr_in = 8'h0F;
    last_n = 1'b1; wdata_in = 32'h7777_0000;
    @(negedge clk);
    @(negedge clk);
    check("R7", "edge beat ready_n", 32'(ready_n), 32'd0);
    wdata_in = 32'h7777_0001;
    @(negedge clk);
    @(negedge clk);
    check("R7", "overrun beat stop_n", 32'(stop_n), 32'd0);
    check("R7", "overrun beat ready_n", 32'(ready_n), 32'd1);
    sel_n = 1'b1; strb_n = 1'b1; last_n = 1'b0;
    sync_xfer("R7", 8'h0F, 1'b0, 2'b11, 32'h0, 1'b1, 1'b0, 1'b1, 32'h7777_0000);
  endtask

  task automatic t_mux();
    do_reset(1'b0, 1'b1);
    sync_xfer("R10", 8'h06, 1'b1, 2'b11, 32'h6666_0006, 1'b1, 1'b0, 1'b0, 32'h0);
    sync_xfer("R10", 8'h06, 1'b0, 2'b11, 32'h0, 1'b1, 1'b0, 1'b1, 32'h6666_0006);
  endtask

  task automatic async_xfer(input logic [7:0] a, input logic w, input logic [31:0] d,
                            input logic chk_rd, input logic [31:0] exp_rd);
    int cyc;
    @(negedge clk);
    sel_n = 1'b0; strb_n = 1'b0; wr = w; word_en = 2'b11;
    last_n = 1'b1; addr_in = a; wdata_in = d;
    cyc = 0;
    while (ready_n && cyc < 10) begin
      @(negedge clk);
      cyc++;
    end
    check("R9", "edges to ready", 32'(cyc), 32'd4);
    check("R9", "stop_n in strobe mode", 32'(stop_n), 32'd1);
    if (chk_rd) check("R9", "async rdata", rdata_out, exp_rd);
    repeat (3) @(negedge clk);
    check("R9", "ready held with strobe", 32'(ready_n), 32'd0);
    sel_n = 1'b1; strb_n = 1'b1;
    @(negedge clk);
    check("R9", "ready still low just after release", 32'(ready_n), 32'd0);
    repeat (2) @(negedge clk);
    check("R9", "ready released", 32'(ready_n), 32'd1);
    check("R9", "stop_n after release", 32'(stop_n), 32'd1);
    @(negedge clk);
  endtask

  task automatic t_async();
    do_reset(1'b1, 1'b0);
    async_xfer(8'h04, 1'b1, 32'h0BAD_F00D, 1'b0, 32'h0);
    async_xfer(8'h04, 1'b0, 32'h0, 1'b1, 32'h0BAD_F00D);
    async_xfer(8'h05, 1'b0, 32'h0, 1'b1, 32'h0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; mode_async = 1'b0; mux_bus = 1'b0;
    bus_idle();
    t_reset();
    t_single();
    t_invalid();
    t_lanes();
    t_stop_gap();
    t_burst();
    t_mux();
    t_async();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule